// File: doc/BRIEF.md
# Multichannel Edge-Compare PWM Controller

This block generates up to sixteen pulse-width modulated outputs from one shared time base. A prescaler divides the input clock, so the period counter moves one step every (prescale + 1) clocks. The counter runs from 0 up to the programmed period value and then returns to 0, so one output cycle lasts (period + 1) steps. Each channel compares the shared count against its own turn-on and turn-off values. Its output is high while the count lies in the half-open window [turn-on, turn-off). The most common use keeps the turn-on value at 0 and sets the duty cycle through the turn-off value alone.

Software programs the block through a single-cycle 32-bit write port with a combinational read port. The channel enables are split over two byte-wide registers. Clearing both registers silences every output and leaves the counters and edge values in place, so the block can be re-enabled with no further action. A deferred-update mode holds edge writes in a shadow copy and moves them into use at the period boundary, so a duty change cannot produce a torn pulse.

Register offsets (byte addresses): prescale 0x00, period 0x04, low enable byte 0x08, high enable byte 0x0C, deferred-update control 0x10 (bit 0). For channel n, counted from 0, the turn-on register is at 0x20 + 8n and the turn-off register is at 0x24 + 8n.

Top module: `edge_pwm_ctrl`

## Requirements
- R1: After reset every register reads 0 and every output is low.
- R2: Each register reads back the last value written, zero-extended to 32 bits. The edge registers return the written value even while it is still deferred. An address outside the map, including edge slots of channels that are not present, reads 0.
- R3: The period counter advances by one every (prescale + 1) clocks. Writing the prescale register clears the prescale phase.
- R4: The counter runs from 0 up to the period value and then wraps to 0. A write to the period register restarts both the counter and the prescale phase at 0.
- R5: An enabled channel drives 1 exactly when turn-on <= count < turn-off. The output is registered, so it shows the count of the previous clock.
- R6: When turn-on >= turn-off, the output stays low for the whole period.
- R7: Channels 0..7 are enabled by bits 0..7 of the low enable byte, and channels 8..15 by bits 0..7 of the high enable byte. A disabled channel drives 0.
- R8: Writing 0 to both enable bytes forces all outputs low from the next clock. Writing the enables again resumes the outputs in phase with the counter, which has kept running.
- R9: With deferred update off (control bit 0 = 0), an edge write affects the output computed on the next clock.
- R10: With deferred update on (control bit 0 = 1), an edge write leaves the active edges unchanged until the counter wraps from the period value to 0. The new values apply from that wrap onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_we | input | 1 | Write strobe; data is written on the rising clock edge |
| bus_addr | input | 8 | Byte address for reads and writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| pwm_out | output | NUM_CH | One pulse output per channel |

## Verification
The output window is swept over every turn-on and turn-off pair from 0 to period+1. This is done for prescale values 0 to 2 and period values 1 to 4, so the sweep covers empty windows, full windows and windows that touch either end. Repeating the sweep across prescale values separates a wrong step rate from a wrong compare. A disabled channel carries the same edges as an enabled one, which separates the enable logic from the compare. A channel in the high enable byte shows whether the byte split is wired correctly. The same mid-period edge change is applied once with deferred update off and once with it on, and the output observed for the rest of that period tells immediate update apart from update at the boundary.

// File: rtl/edge_pwm_pkg.sv
// Shared constants for the edge-compare PWM controller: bus widths and
// the register address map. Assumes byte addressing with 32-bit words.
package edge_pwm_pkg;
    localparam int BUS_W        = 32;
    localparam int ADDR_W       = 8;
    localparam int EN_BYTE_W    = 8;
    localparam int EDGE_STRIDE  = 8;
    localparam int FALL_OFFSET  = 4;
    localparam int EDGE_BASE    = 32;

    localparam logic [ADDR_W-1:0] ADR_PRESCALE = 8'h00;
    localparam logic [ADDR_W-1:0] ADR_PERIOD   = 8'h04;
    localparam logic [ADDR_W-1:0] ADR_EN_LO    = 8'h08;
    localparam logic [ADDR_W-1:0] ADR_EN_HI    = 8'h0C;
    localparam logic [ADDR_W-1:0] ADR_SYNC     = 8'h10;

    // Address of a channel's turn-on (fall=0) or turn-off (fall=1) register
    function automatic logic [ADDR_W-1:0] edge_addr(input int ch, input bit fall);
        return ADDR_W'(EDGE_BASE + ch * EDGE_STRIDE + (fall ? FALL_OFFSET : 0));
    endfunction
endpackage

// File: rtl/edge_pwm_regs.sv
// Register file of the PWM controller. Holds the prescale, period,
// enable and deferred-update settings, plus a written (shadow) and an
// active copy of each channel's edges. The active copy follows writes
// at once unless deferred update is on; in that case it is refreshed
// only on the wrap pulse. Assumes NUM_CH <= 16.
module edge_pwm_regs
    import edge_pwm_pkg::*;
#(
    parameter int NUM_CH = 16,
    parameter int CNT_W  = 32
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           bus_we,
    input  logic [ADDR_W-1:0]              bus_addr,
    input  logic [BUS_W-1:0]               bus_wdata,
    input  logic                           wrap,
    output logic [BUS_W-1:0]               bus_rdata,
    output logic [CNT_W-1:0]               prescale,
    output logic [CNT_W-1:0]               period,
    output logic                           prescale_wr,
    output logic                           period_wr,
    output logic                           sync_mode,
    output logic [NUM_CH-1:0]              en_vec,
    output logic [NUM_CH-1:0][CNT_W-1:0]   rise_act,
    output logic [NUM_CH-1:0][CNT_W-1:0]   fall_act
);
    logic [EN_BYTE_W-1:0]             en_lo;
    logic [EN_BYTE_W-1:0]             en_hi;
    logic [NUM_CH-1:0][CNT_W-1:0]     rise_sh;
    logic [NUM_CH-1:0][CNT_W-1:0]     fall_sh;
    logic                             unused_bits;

    assign prescale_wr = bus_we && (bus_addr == ADR_PRESCALE);
    assign period_wr   = bus_we && (bus_addr == ADR_PERIOD);

    // Global settings: write on strobe, hold otherwise
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prescale  <= '0;
            period    <= '0;
            en_lo     <= '0;
            en_hi     <= '0;
            sync_mode <= 1'b0;
        end else if (bus_we) begin
            case (bus_addr)
                ADR_PRESCALE: prescale  <= bus_wdata[CNT_W-1:0];
                ADR_PERIOD:   period    <= bus_wdata[CNT_W-1:0];
                ADR_EN_LO:    en_lo     <= bus_wdata[EN_BYTE_W-1:0];
                ADR_EN_HI:    en_hi     <= bus_wdata[EN_BYTE_W-1:0];
                ADR_SYNC:     sync_mode <= bus_wdata[0];
                default:      ;
            endcase
        end
    end

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        localparam logic [ADDR_W-1:0] RISE_A = edge_addr(i, 1'b0);
        localparam logic [ADDR_W-1:0] FALL_A = edge_addr(i, 1'b1);
        logic hit_rise;
        logic hit_fall;
        logic [CNT_W-1:0] r_sh, f_sh, r_act, f_act;

        assign hit_rise = bus_we && (bus_addr == RISE_A);
        assign hit_fall = bus_we && (bus_addr == FALL_A);

        // Shadow edges: always take the written value
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                r_sh <= '0;
                f_sh <= '0;
            end else begin
                if (hit_rise) r_sh <= bus_wdata[CNT_W-1:0];
                if (hit_fall) f_sh <= bus_wdata[CNT_W-1:0];
            end
        end

        // Active edges: copy on wrap, direct write when not deferred
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                r_act <= '0;
                f_act <= '0;
            end else begin
                if (wrap) begin
                    r_act <= r_sh;
                    f_act <= f_sh;
                end
                if (!sync_mode && hit_rise) r_act <= bus_wdata[CNT_W-1:0];
                if (!sync_mode && hit_fall) f_act <= bus_wdata[CNT_W-1:0];
            end
        end

        assign rise_sh[i]  = r_sh;
        assign fall_sh[i]  = f_sh;
        assign rise_act[i] = r_act;
        assign fall_act[i] = f_act;

        if (i < EN_BYTE_W) begin : g_lo
            assign en_vec[i] = en_lo[i];
        end else begin : g_hi
            assign en_vec[i] = en_hi[i-EN_BYTE_W];
        end
    end

    // Read mux: fixed registers, then per-channel edge slots
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            ADR_PRESCALE: bus_rdata = BUS_W'(prescale);
            ADR_PERIOD:   bus_rdata = BUS_W'(period);
            ADR_EN_LO:    bus_rdata = BUS_W'(en_lo);
            ADR_EN_HI:    bus_rdata = BUS_W'(en_hi);
            ADR_SYNC:     bus_rdata = BUS_W'(sync_mode);
            default:      ;
        endcase
        for (int i = 0; i < NUM_CH; i++) begin
            if (bus_addr == edge_addr(i, 1'b0)) bus_rdata = BUS_W'(rise_sh[i]);
            if (bus_addr == edge_addr(i, 1'b1)) bus_rdata = BUS_W'(fall_sh[i]);
        end
    end

    assign unused_bits = ^{bus_wdata, en_lo, en_hi};
endmodule

// File: rtl/edge_pwm_timebase.sv
// Shared time base: a prescaler that produces one step pulse every
// (prescale + 1) clocks and a period counter running 0..period.
// A period write restarts both; a prescale write clears the prescaler.
// wrap marks the step on which the counter returns to 0.
module edge_pwm_timebase #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] prescale,
    input  logic [CNT_W-1:0] period,
    input  logic             prescale_wr,
    input  logic             period_wr,
    output logic [CNT_W-1:0] count,
    output logic             step,
    output logic             wrap
);
    logic [CNT_W-1:0] pre_q;

    assign step = (pre_q >= prescale) && !period_wr && !prescale_wr;
    assign wrap = step && (count >= period);

    // Prescaler and period counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_q <= '0;
            count <= '0;
        end else if (period_wr) begin
            pre_q <= '0;
            count <= '0;
        end else if (prescale_wr) begin
            pre_q <= '0;
        end else if (step) begin
            pre_q <= '0;
            count <= wrap ? '0 : count + 1'b1;
        end else begin
            pre_q <= pre_q + 1'b1;
        end
    end
endmodule

// File: rtl/edge_pwm_channel.sv
// One output channel: a registered window compare of the shared count
// against the active turn-on and turn-off values. An empty window
// (turn-on >= turn-off) or a cleared enable gives a low output.
module edge_pwm_channel #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [CNT_W-1:0] count,
    input  logic [CNT_W-1:0] rise,
    input  logic [CNT_W-1:0] fall,
    output logic             pwm
);
    // Output register: high inside [rise, fall) when enabled
    always_ff @(posedge clk) begin
        if (!rst_n) pwm <= 1'b0;
        else        pwm <= enable && (count >= rise) && (count < fall);
    end
endmodule

// File: rtl/edge_pwm_ctrl.sv
// Top of the edge-compare PWM controller. Wires the register file,
// the shared time base and one compare channel per output.
// Assumes 1 <= NUM_CH <= 16 and CNT_W <= 32.
module edge_pwm_ctrl
    import edge_pwm_pkg::*;
#(
    parameter int NUM_CH = 16,
    parameter int CNT_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [7:0]        bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic [NUM_CH-1:0] pwm_out
);
    logic [CNT_W-1:0]             prescale, period, count;
    logic                         prescale_wr, period_wr, sync_mode, step, wrap;
    logic [NUM_CH-1:0]            en_vec;
    logic [NUM_CH-1:0][CNT_W-1:0] rise_act, fall_act;

    edge_pwm_regs #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .wrap(wrap), .bus_rdata(bus_rdata),
        .prescale(prescale), .period(period), .prescale_wr(prescale_wr),
        .period_wr(period_wr), .sync_mode(sync_mode), .en_vec(en_vec),
        .rise_act(rise_act), .fall_act(fall_act)
    );

    edge_pwm_timebase #(.CNT_W(CNT_W)) u_tbase (
        .clk(clk), .rst_n(rst_n), .prescale(prescale), .period(period),
        .prescale_wr(prescale_wr), .period_wr(period_wr),
        .count(count), .step(step), .wrap(wrap)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_out
        edge_pwm_channel #(.CNT_W(CNT_W)) u_chan (
            .clk(clk), .rst_n(rst_n), .enable(en_vec[i]), .count(count),
            .rise(rise_act[i]), .fall(fall_act[i]), .pwm(pwm_out[i])
        );
    end
endmodule

// File: rtl/edge_pwm_ctrl_chk.sv
// Property checker for the PWM controller, bound to the top module.
// Observes the time base, the active edges and the outputs.
module edge_pwm_ctrl_chk #(
    parameter int NUM_CH = 16,
    parameter int CNT_W  = 32
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic [CNT_W-1:0]             count,
    input logic [CNT_W-1:0]             period,
    input logic                         step,
    input logic                         wrap,
    input logic                         period_wr,
    input logic                         sync_mode,
    input logic [NUM_CH-1:0]            en_vec,
    input logic [NUM_CH-1:0][CNT_W-1:0] rise_act,
    input logic [NUM_CH-1:0][CNT_W-1:0] fall_act,
    input logic [NUM_CH-1:0]            pwm_out
);
    p_count_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        count <= period);

    p_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
        period_wr |=> (count == '0));

    p_wrap_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> (count == '0));

    p_step_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !period_wr) |=> $stable(count));

    p_disabled_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pwm_out & ~$past(en_vec)) == '0));

    p_stop_all_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (en_vec == '0) |=> (pwm_out == '0));

    p_deferred_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_mode && !wrap) |=> ($stable(rise_act) && $stable(fall_act)));

    for (genvar i = 0; i < NUM_CH; i++) begin : g_win
        p_empty_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (rise_act[i] >= fall_act[i]) |=> !pwm_out[i]);
    end
endmodule

bind edge_pwm_ctrl edge_pwm_ctrl_chk #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .count(count), .period(period), .step(step),
    .wrap(wrap), .period_wr(period_wr), .sync_mode(sync_mode),
    .en_vec(en_vec), .rise_act(rise_act), .fall_act(fall_act),
    .pwm_out(pwm_out)
);

// File: tb/edge_pwm_ctrl_test.sv
module edge_pwm_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int NCH = 10;
    localparam int CW  = 8;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           bus_we = 1'b0;
    logic [7:0]     bus_addr = '0;
    logic [31:0]    bus_wdata = '0;
    logic [31:0]    bus_rdata;
    logic [NCH-1:0] pwm_out;

    int tests = 0;
    int fails = 0;
    int cyc = 0;
    int t0 = 0;
    bit done = 1'b0;

    edge_pwm_ctrl #(.NUM_CH(NCH), .CNT_W(CW)) uut (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_out(pwm_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic int ea(int ch, int fall);
        return 32 + 8 * ch + 4 * fall;
    endfunction

    function automatic bit win(int r, int f, int c);
        return (c >= r) && (c < f);
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    task automatic wr(int a, int d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = 8'(a); bus_wdata = 32'(d);
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rdchk(string tag, int a, int exp);
        @(negedge clk);
        bus_addr = 8'(a);
        #1;
        chk(tag, bus_rdata, 32'(exp));
    endtask

    // Count value used for the output seen t clocks after the period write
    function automatic int cnt_at(int t, int p, int n);
        return ((t - 1) / (p + 1)) % (n + 1);
    endfunction

    task automatic start_period(int n);
        wr(32'h04, n);
        t0 = cyc;
    endtask

    task automatic run_cfg(int p, int n, int r, int f);
        wr(32'h00, p);
        wr(ea(0, 0), r); wr(ea(0, 1), f);
        wr(ea(1, 0), r); wr(ea(1, 1), f);
        wr(ea(9, 0), 0); wr(ea(9, 1), n);
        start_period(n);
        for (int k = 0; k < 2 * (n + 1) * (p + 1); k++) begin
            int t, c;
            @(negedge clk);
            t = cyc - t0;
            c = cnt_at(t, p, n);
            if (r < f) chk("R5 ch0 window (steps R3, wrap R4)", 32'(pwm_out[0]), 32'(win(r, f, c)));
            else       chk("R6 ch0 empty window", 32'(pwm_out[0]), 32'(0));
            chk("R7 ch1 disabled low", 32'(pwm_out[1]), 32'(0));
            chk("R7 ch9 high byte enable", 32'(pwm_out[9]), 32'(win(0, n, c)));
        end
    endtask

    // Mid-period change of ch0 turn-off from 2 to 6 with P=0, N=7
    task automatic edge_change(bit deferred);
        int tw;
        wr(32'h10, 0);
        wr(32'h00, 0);
        wr(ea(0, 0), 0); wr(ea(0, 1), 2);
        wr(32'h10, deferred ? 1 : 0);
        start_period(7);
        repeat (2) @(negedge clk);
        wr(ea(0, 1), 6);
        tw = cyc - t0;
        if (deferred) rdchk("R10 readback of deferred value", ea(0, 1), 6);
        else          rdchk("R2 readback of edge value", ea(0, 1), 6);
        for (int k = 0; k < 24; k++) begin
            int t, c, f;
            @(negedge clk);
            t = cyc - t0;
            c = cnt_at(t, 0, 7);
            if (deferred) f = (((t - 1) / 8) >= 1) ? 6 : 2;
            else          f = (t > tw) ? 6 : 2;
            if (deferred) chk("R10 deferred edge applies at wrap", 32'(pwm_out[0]), 32'(win(0, f, c)));
            else          chk("R9 immediate edge update", 32'(pwm_out[0]), 32'(win(0, f, c)));
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        chk("R1 outputs low after reset", 32'(pwm_out), 32'(0));
        rdchk("R1 prescale reset", 32'h00, 0);
        rdchk("R1 period reset", 32'h04, 0);
        rdchk("R1 enable low reset", 32'h08, 0);
        rdchk("R1 enable high reset", 32'h0C, 0);
        rdchk("R1 sync reset", 32'h10, 0);
        rdchk("R1 edge reset", ea(9, 1), 0);
        // R2: readback and unused addresses
        wr(32'h00, 32'h03);  rdchk("R2 prescale readback", 32'h00, 32'h03);
        wr(32'h04, 32'hC5);  rdchk("R2 period readback", 32'h04, 32'hC5);
        wr(32'h08, 32'hA4);  rdchk("R2 enable low readback", 32'h08, 32'hA4);
        wr(32'h0C, 32'h5A);  rdchk("R2 enable high readback", 32'h0C, 32'h5A);
        wr(32'h10, 1);       rdchk("R2 sync readback", 32'h10, 1);
        wr(ea(9, 0), 32'h3C); rdchk("R2 edge readback", ea(9, 0), 32'h3C);
        wr(32'h14, 32'h77);  rdchk("R2 unused address reads zero", 32'h14, 0);
        wr(ea(10, 1), 32'h11); rdchk("R2 absent channel reads zero", ea(10, 1), 0);
        wr(32'h10, 0);
        // R5/R6/R7 sweep: ch0 and ch1 share edges, ch1 disabled, ch9 in high byte
        wr(32'h08, 32'h01);
        wr(32'h0C, 32'h02);
        for (int p = 0; p <= 2; p++)
            for (int n = 1; n <= 4; n++)
                for (int r = 0; r <= n + 1; r++)
                    for (int f = 0; f <= n + 1; f++)
                        run_cfg(p, n, r, f);
        // R9 and R10
        edge_change(1'b0);
        edge_change(1'b1);
        wr(32'h10, 0);
        // R8: stop and resume
        wr(32'h00, 1);
        wr(ea(0, 0), 0); wr(ea(0, 1), 2);
        wr(ea(9, 0), 1); wr(ea(9, 1), 3);
        start_period(3);
        repeat (5) @(negedge clk);
        wr(32'h08, 0);
        wr(32'h0C, 0);
        @(negedge clk);
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            chk("R8 all outputs low when stopped", 32'(pwm_out), 32'(0));
        end
        wr(32'h08, 32'h01);
        wr(32'h0C, 32'h02);
        for (int k = 0; k < 16; k++) begin
            int t, c;
            @(negedge clk);
            t = cyc - t0;
            c = cnt_at(t, 1, 3);
            chk("R8 ch0 resumes in phase", 32'(pwm_out[0]), 32'(win(0, 2, c)));
            chk("R8 ch9 resumes in phase", 32'(pwm_out[9]), 32'(win(1, 3, c)));
        end
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule